// File: doc/BRIEF.md
# Serial Control-Word Front End for an Eight-Channel Sampling Converter

This block is the digital side of a small sampling converter's serial port, seen from the device. The host pulls an active-low select low, toggles a serial clock and drives a data line. The block skips leading zeros, treats the first sampled '1' as the start of a control word and shifts in seven more bits. Those bits choose the input channel, single-ended or differential input, the output code, and one of four power/clock modes. It then runs the conversion, either counted on the host's serial clock or timed on the system clock. It takes an 8-bit offset-binary sample from an abstract converter port and shifts the coded result out MSB first, followed by zeros.

All logic runs on one system clock. The serial clock and select are treated as already synchronous to it and are edge-detected internally. Input bits are taken on serial-clock rising edges and the output changes on falling edges. A strobe output stays high for the whole conversion phase. The analog multiplexer, the converter core and the power circuitry sit outside the block, so only their control pins appear here.

Top module: `adc_serial_if`

## Requirements
- R1: After reset, `dout`, `conv_strobe` and `conv_start` are 0, `pwr_mode` is 2'b00 and `mux_pos` is 0.
- R2: While select is low, zeros on `din` before the first sampled '1' are ignored. That '1' starts a word, and the next seven rising-edge bits are, in order: channel bits [2:0] (MSB first), code bit, input-mode bit, mode bits [1:0].
- R3: With input-mode bit 1 (single-ended), `mux_single`=1, `mux_pos` equals the channel bits and `mux_neg`=0. With input-mode bit 0 (differential), `mux_single`=0, `mux_pos` equals the channel bits and `mux_neg` equals the channel bits with bit 0 inverted.
- R4: Code bit 1 (unipolar) sends `conv_data` unchanged. Code bit 0 (bipolar) sends `conv_data` with its MSB inverted (two's complement).
- R5: Mode 2'b11 (serial-clock conversion) pulses `conv_start` once. `conv_strobe` is high from just after the 8th rising edge until the 16th falling edge. The result's bits B7..B0 appear on `dout` after falling edges 16..23.
- R6: Once the result's LSB has been shifted out, further falling edges drive `dout` to 0.
- R7: Mode 2'b10 (internal timebase) pulses `conv_start` and holds `conv_strobe` high for exactly CONV_CYCLES system clocks. Then `dout` shows B7, and each serial falling edge advances one bit.
- R8: While a result is being shifted out, a new start bit and control word are accepted, and the outgoing result is not disturbed.
- R9: While `conv_strobe` is high, `din` is ignored: a '1' there does not start a word.
- R10: Modes 2'b00 and 2'b01 are latched to `pwr_mode`. They start no conversion: no `conv_start`, `conv_strobe` stays low and `dout` keeps sending zeros.
- R11: Raising `cs_n` abandons any partial word, conversion or result output. `dout` and `conv_strobe` are 0 one system clock later, and the next word needs a fresh start bit.
- R12: Serial clock edges are ignored while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, synchronous to clk |
| din | input | 1 | Serial data in |
| conv_data | input | DATA_W | Offset-binary sample from the converter core |
| dout | output | 1 | Serial result out |
| conv_strobe | output | 1 | High during the conversion phase |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| mux_pos | output | 3 | Positive input channel |
| mux_neg | output | 3 | Negative input channel (0 when single-ended) |
| mux_single | output | 1 | 1 = single-ended input |
| pwr_mode | output | 2 | Mode bits of the last control word |

## Verification
The bench builds the block with DATA_W=8 and a short internal timebase of CONV_CYCLES=12. This lets it measure the exact length of the internal-clock strobe and run two overlapped internal frames in a few hundred clocks. The serial clock runs at one quarter of the system clock. That leaves room for the one-cycle lag of the decoded word before the next rising edge, which is the tightest margin the design assumes.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  typedef enum logic [1:0] {
    PM_FULL_OFF = 2'b00,
    PM_FAST_OFF = 2'b01,
    PM_INT_CLK  = 2'b10,
    PM_EXT_CLK  = 2'b11
  } pmode_e;

  // field order equals serial arrival order after the start bit
  typedef struct packed {
    logic [2:0] chan;
    logic       uni;
    logic       single;
    pmode_e     pmode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/adc_ctrl_rx.sv
module adc_ctrl_rx
  import adc_sif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  abort,
  input  logic  rise,
  input  logic  din,
  input  logic  rx_en,
  output ctrl_t ctrl_q,
  output logic  done_q
);

  localparam int unsigned CNT_W = $clog2(CTRL_W + 1);

  typedef enum logic {RX_HUNT, RX_SHIFT} rx_st_e;

  rx_st_e            st_q, st_d;
  logic [CTRL_W-2:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  ctrl_t             ctrl_d;
  logic              done_d;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    ctrl_d = ctrl_q;
    done_d = 1'b0;
    if (abort) begin
      st_d  = RX_HUNT;
      cnt_d = '0;
    end else if (rise) begin
      unique case (st_q)
        RX_HUNT: begin
          if (rx_en && din) begin
            st_d  = RX_SHIFT;
            cnt_d = '0;
          end
        end
        RX_SHIFT: begin
          sh_d = {sh_q[CTRL_W-3:0], din};
          if (cnt_q == CNT_W'(CTRL_W - 1)) begin
            st_d   = RX_HUNT;
            cnt_d  = '0;
            done_d = 1'b1;
            ctrl_d = ctrl_t'({sh_q, din});
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = RX_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_HUNT;
      sh_q   <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      ctrl_q <= ctrl_d;
      done_q <= done_d;
    end
  end

  // R9: receiver never leaves hunting while the sequencer blocks it
  p_rx_blocked_hunts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (st_q == RX_HUNT));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_sif_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 64,
  parameter int unsigned EXT_CLKS    = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   abort,
  input  logic   rise,
  input  logic   fall,
  input  logic   start,
  input  pmode_e pmode,
  output logic   conv_start,
  output logic   busy,
  output logic   load
);

  localparam int unsigned MAXC = (CONV_CYCLES > EXT_CLKS) ? CONV_CYCLES : EXT_CLKS;
  localparam int unsigned TW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_EXT, SQ_INT} sq_st_e;

  sq_st_e        st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;

  assign busy       = (st_q != SQ_IDLE);
  assign conv_start = start && pmode[1] && !abort;
  assign load = !abort &&
                (((st_q == SQ_EXT) && fall && (cnt_q == TW'(EXT_CLKS))) ||
                 ((st_q == SQ_INT) && (cnt_q == TW'(CONV_CYCLES - 1))));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (abort) begin
      st_d  = SQ_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          cnt_d = '0;
          if (start && pmode == PM_EXT_CLK) st_d = SQ_EXT;
          else if (start && pmode == PM_INT_CLK) st_d = SQ_INT;
        end
        SQ_EXT: begin
          if (load) st_d = SQ_IDLE;
          else if (rise && cnt_q < TW'(EXT_CLKS)) cnt_d = cnt_q + 1'b1;
        end
        SQ_INT: begin
          if (load) st_d = SQ_IDLE;
          else cnt_d = cnt_q + 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R5: conversion phase only begins right after a start pulse
  p_busy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(conv_start));

  // R10: a power-down word leaves the sequencer idle
  p_pd_no_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pmode[1] && !busy) |=> !busy);

endmodule

// File: rtl/adc_res_shift.sv
module adc_res_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              fall,
  input  logic              load,
  input  logic              uni,
  input  logic [DATA_W-1:0] raw,
  output logic              dout
);

  logic [DATA_W-1:0] sh_q, sh_d, coded;

  // offset binary in; bipolar output flips the sign bit
  assign coded = uni ? raw : {~raw[DATA_W-1], raw[DATA_W-2:0]};

  always_comb begin
    sh_d = sh_q;
    if (abort)     sh_d = '0;
    else if (load) sh_d = coded;
    else if (fall) sh_d = {sh_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[DATA_W-1];

endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adc_sif_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CONV_CYCLES = 64,
  parameter int unsigned EXT_CLKS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              conv_strobe,
  output logic              conv_start,
  output logic [2:0]        mux_pos,
  output logic [2:0]        mux_neg,
  output logic              mux_single,
  output logic [1:0]        pwr_mode
);

  logic  sclk_q, rise, fall, busy, load, done;
  ctrl_t ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk && !sclk_q && !cs_n;
  assign fall = !sclk && sclk_q && !cs_n;

  adc_ctrl_rx u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (cs_n),
    .rise   (rise),
    .din    (din),
    .rx_en  (!busy),
    .ctrl_q (ctrl),
    .done_q (done)
  );

  adc_conv_seq #(
    .CONV_CYCLES (CONV_CYCLES),
    .EXT_CLKS    (EXT_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (cs_n),
    .rise       (rise),
    .fall       (fall),
    .start      (done),
    .pmode      (ctrl.pmode),
    .conv_start (conv_start),
    .busy       (busy),
    .load       (load)
  );

  adc_res_shift #(.DATA_W(DATA_W)) u_sh (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (cs_n),
    .fall  (fall),
    .load  (load),
    .uni   (ctrl.uni),
    .raw   (conv_data),
    .dout  (dout)
  );

  assign conv_strobe = busy;
  assign mux_pos     = ctrl.chan;
  assign mux_single  = ctrl.single;
  assign mux_neg     = ctrl.single ? 3'd0 : {ctrl.chan[2:1], ~ctrl.chan[0]};
  assign pwr_mode    = ctrl.pmode;

  // R11: deselect silences output and strobe on the next clock
  p_deselect_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!dout && !conv_strobe));

endmodule

// File: tb/adc_serial_if_bench.sv
module adc_serial_if_bench;

  localparam int unsigned DW = 8;
  localparam int unsigned CC = 12;

  logic          clk, rst_n, cs_n, sclk, din;
  logic [DW-1:0] conv_data;
  logic          dout, conv_strobe, conv_start, mux_single;
  logic [2:0]    mux_pos, mux_neg;
  logic [1:0]    pwr_mode;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int cyc    = 0;

  adc_serial_if #(.DATA_W(DW), .CONV_CYCLES(CC), .EXT_CLKS(8)) u_adc_serial_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .conv_data(conv_data), .dout(dout), .conv_strobe(conv_strobe),
    .conv_start(conv_start), .mux_pos(mux_pos), .mux_neg(mux_neg),
    .mux_single(mux_single), .pwr_mode(pwr_mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (conv_start) starts <= starts + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one serial clock: drive din, sample dout/strobe just before the rise
  task automatic sbit(input logic b, output logic d_s, output logic s_s);
    @(negedge clk) din = b;
    @(negedge clk);
    d_s  = dout;
    s_s  = conv_strobe;
    sclk = 1'b1;
    @(negedge clk);
    @(negedge clk) sclk = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] st);
    for (int i = 7; i >= 0; i--) begin
      logic d, s;
      sbit(tx[i], d, s);
      rx[i] = d;
      st[i] = s;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 dout", dout, 0);
    chk("R1 strobe", conv_strobe, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 pwr_mode", pwr_mode, 0);
    chk("R1 mux_pos", mux_pos, 0);
  endtask

  task automatic t_ext_uni;
    logic [7:0] rx, st;
    logic d, s;
    int base;
    base = starts;
    cs_n = 1'b0;
    conv_data = 8'hA5;
    repeat (3) sbit(1'b0, d, s);           // R2 leading zeros
    sbyte(8'b1_101_1_1_11, rx, st);
    chk("R2 mux_pos", mux_pos, 5);
    chk("R3 single", mux_single, 1);
    chk("R3 neg single", mux_neg, 0);
    chk("R2 pwr_mode", pwr_mode, 3);
    sbyte(8'h00, rx, st);
    chk("R5 strobe clocks 9-16", st, 8'hFF);
    sbyte(8'h00, rx, st);
    chk("R4 R5 unipolar result", rx, 8'hA5);
    chk("R5 strobe after result", st, 8'h00);
    sbyte(8'h00, rx, st);
    chk("R6 zero fill", rx, 8'h00);
    chk("R5 one start pulse", starts - base, 1);
    @(negedge clk) cs_n = 1'b1;
    idle(4);
  endtask

  task automatic t_ext_bip;
    logic [7:0] rx, st;
    int base;
    base = starts;
    cs_n = 1'b0;
    conv_data = 8'h3C;
    sbyte(8'b1_010_0_0_11, rx, st);
    chk("R3 diff pos", mux_pos, 2);
    chk("R3 diff neg", mux_neg, 3);
    chk("R3 diff flag", mux_single, 0);
    sbyte(8'hFF, rx, st);                   // R9 ones during conversion
    chk("R9 strobe held", st, 8'hFF);
    sbyte(8'h00, rx, st);
    chk("R4 bipolar result", rx, 8'hBC);
    chk("R9 no extra start", starts - base, 1);
    chk("R9 strobe idle", conv_strobe, 0);
    @(negedge clk) cs_n = 1'b1;
    idle(4);
  endtask

  task automatic t_int_overlap;
    logic [7:0] rx, st;
    int base, n, w;
    base = starts;
    cs_n = 1'b0;
    conv_data = 8'h81;
    sbyte(8'b1_111_1_1_10, rx, st);
    chk("R7 pwr_mode int", pwr_mode, 2);
    chk("R3 pos ch7", mux_pos, 7);
    w = 0;
    while (!conv_strobe && w < 50) begin @(negedge clk); w++; end
    n = 0;
    while (conv_strobe && n < 100) begin @(negedge clk); n++; end
    chk("R7 strobe length", n, CC);
    chk("R7 B7 present", dout, 1);
    conv_data = 8'h00;
    sbyte(8'b1_000_0_0_10, rx, st);         // R8 next word during output
    chk("R8 result intact", rx, 8'h81);
    chk("R8 new word pos", mux_pos, 0);
    chk("R8 new word neg", mux_neg, 1);
    chk("R8 new word diff", mux_single, 0);
    w = 0;
    while (conv_strobe && w < 100) begin @(negedge clk); w++; end
    sbyte(8'h00, rx, st);
    chk("R4 R8 second result", rx, 8'h80);
    chk("R7 two starts", starts - base, 2);
    @(negedge clk) cs_n = 1'b1;
    idle(4);
  endtask

  task automatic t_powerdown;
    logic [7:0] rx, st;
    int base;
    base = starts;
    cs_n = 1'b0;
    sbyte(8'b1_011_1_1_01, rx, st);
    chk("R10 fast off latched", pwr_mode, 1);
    sbyte(8'h00, rx, st);
    chk("R10 no strobe", st, 8'h00);
    chk("R10 dout zeros", rx, 8'h00);
    sbyte(8'b1_000_1_1_00, rx, st);
    chk("R10 full off latched", pwr_mode, 0);
    sbyte(8'h00, rx, st);
    chk("R10 no strobe full", st, 8'h00);
    chk("R10 no start", starts - base, 0);
    @(negedge clk) cs_n = 1'b1;
    idle(4);
  endtask

  task automatic t_abort;
    logic [7:0] rx, st;
    logic d, s;
    int base;
    base = starts;
    cs_n = 1'b0;
    repeat (3) sbit(1'b1, d, s);            // partial word
    @(negedge clk) cs_n = 1'b1;
    repeat (8) sbit(1'b1, d, s);            // R12 edges while deselected
    chk("R12 no start", starts - base, 0);
    chk("R12 pwr_mode kept", pwr_mode, 0);
    @(negedge clk) cs_n = 1'b0;
    sbyte(8'b1_011_1_1_01, rx, st);
    chk("R11 fresh word pwr", pwr_mode, 1);
    chk("R11 fresh word pos", mux_pos, 3);
    sbyte(8'b1_101_1_1_11, rx, st);
    repeat (3) sbit(1'b0, d, s);
    chk("R11 strobe before abort", conv_strobe, 1);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    chk("R11 strobe dropped", conv_strobe, 0);
    idle(2);
    @(negedge clk) cs_n = 1'b0;
    conv_data = 8'hFF;
    sbyte(8'b1_101_1_1_11, rx, st);
    sbyte(8'h00, rx, st);
    repeat (3) sbit(1'b0, d, s);
    chk("R11 dout high before abort", dout, 1);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    chk("R11 dout cleared", dout, 0);
    idle(4);
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b1;
    sclk = 1'b0;
    din = 1'b0;
    conv_data = '0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    t_reset;
    t_ext_uni;
    t_ext_bip;
    t_int_overlap;
    t_powerdown;
    t_abort;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule